// File: doc/BRIEF.md
# Feed-Protected PLL Configuration Registers

This block is a small memory-mapped register file that sits between a bus master and a clock-synthesis PLL. Software stages an enable bit, a connect bit, a 15-bit feedback multiplier and an 8-bit pre-divider in two holding registers. None of these staged values reach the PLL until software performs a two-write unlock on a dedicated feed register. At that point all staged values are copied at once into shadow registers, and the shadow registers are what drive the PLL pins.

A read-only status register reports the shadow values, which are what the PLL is actually running with, together with the live lock indication. This lets software tell a staged but unfed change apart from an applied one. The connect output, which moves the system clock onto the PLL, is gated so that it is only asserted while the PLL is enabled and reports lock.

The bus port is a single-cycle synchronous slave. An access is a cycle with `bus_sel` high. Read data is registered and returned on the cycle after the read.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, `pll_enable`, `pll_connect`, `pll_msel` and `pll_nsel` are zero, and every register reads back as zero.
- R2: Writing the control register (byte offset 0x0) or the configuration register (offset 0x4) changes no PLL output. These registers read back only their defined fields: control bit 0 is enable and bit 1 is connect; configuration bits 14:0 are the multiplier and bits 23:16 are the pre-divider. All other bits read as zero.
- R3: A write of 0x000000AA to the feed register (offset 0xC), followed by a write of 0x00000055 as the next bus access, copies both holding registers into the shadows. The PLL outputs take the new values at the clock edge that samples the 0x55 write.
- R4: A status read (offset 0x8) returns the shadow multiplier at bits 14:0, the shadow pre-divider at bits 23:16, shadow enable at bit 24, shadow connect at bit 25 and the lock input at bit 26, with all other bits zero.
- R5: Read data appears on `bus_rdata` in the cycle after the read access and holds until the next read. Reads of the feed register, of unaligned addresses and of offsets at or above 0x10 return zero.
- R6: `pll_connect` is high only while the shadow connect bit, the shadow enable bit and `pll_lock` are all high.
- R7: Certain events after the 0xAA write and before the 0x55 write abort the sequence and leave the shadows unchanged. These are a feed write of any other value, or any other bus access, including reads and writes to other registers. A new 0xAA feed write re-arms the sequence.
- R8: Idle cycles (`bus_sel` low) between the two feed writes do not abort the sequence.
- R9: Writes to the status register, to unaligned addresses and to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| pll_lock | input | 1 | Lock indication from the PLL |
| pll_enable | output | 1 | Shadow enable to the PLL |
| pll_connect | output | 1 | Clock-source switch, gated by enable and lock |
| pll_msel | output | MUL_W (15) | Shadow feedback multiplier |
| pll_nsel | output | DIV_W (8) | Shadow pre-divider |

## Verification
The checker assumes that `pll_lock` comes from a clock domain already synchronised to `clk`, and that `bus_addr`, `bus_wr` and `bus_wdata` are stable and meaningful whenever `bus_sel` is high. It treats every selected cycle as exactly one access.

The bench drives all bus and lock inputs one nanosecond after a rising edge and holds them for a full cycle. Each access lasts exactly one selected cycle. `pll_lock` changes only while the bus is idle, so a status read never races a lock transition.

// File: rtl/pllreg_pkg.sv
package pllreg_pkg;

  // Word index within the mapped window; the order fixes the byte offsets.
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CFG  = 2'd1,
    REG_STAT = 2'd2,
    REG_FEED = 2'd3
  } reg_idx_t;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feed_state_t;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CONN_BIT = 1;
  localparam int CFG_NSEL_LSB  = 16;
  localparam int STAT_EN_BIT   = 24;
  localparam int STAT_CONN_BIT = 25;
  localparam int STAT_LOCK_BIT = 26;

endpackage

// File: rtl/pllreg_rst_sync.sv
module pllreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pllreg_decode.sv
module pllreg_decode
  import pllreg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              mapped,
  output reg_idx_t          reg_idx,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              wr_feed,
  output logic              rd_acc
);

  localparam int WIN_BITS = 4;

  logic in_window;

  always_comb begin
    in_window = ((bus_addr >> WIN_BITS) == '0);
    mapped    = in_window && (bus_addr[1:0] == 2'b00);
    reg_idx   = reg_idx_t'(bus_addr[3:2]);
    wr_ctrl   = bus_sel && bus_wr && mapped && (reg_idx == REG_CTRL);
    wr_cfg    = bus_sel && bus_wr && mapped && (reg_idx == REG_CFG);
    wr_feed   = bus_sel && bus_wr && mapped && (reg_idx == REG_FEED);
    rd_acc    = bus_sel && !bus_wr;
  end

endmodule

// File: rtl/pllreg_feed.sv
module pllreg_feed
  import pllreg_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY_A  = 32'h0000_00AA,
  parameter logic [31:0] KEY_B  = 32'h0000_0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              wr_feed,
  input  logic [DATA_W-1:0] wdata,
  output logic              commit
);

  localparam logic [DATA_W-1:0] KA = DATA_W'(KEY_A);
  localparam logic [DATA_W-1:0] KB = DATA_W'(KEY_B);

  feed_state_t st_q;
  feed_state_t st_d;
  logic        is_key_a;
  logic        is_key_b;

  always_comb begin
    is_key_a = wr_feed && (wdata == KA);
    is_key_b = wr_feed && (wdata == KB);
    st_d     = st_q;
    commit   = 1'b0;
    if (bus_sel) begin
      if (is_key_a) begin
        st_d = FEED_ARMED;
      end else begin
        st_d   = FEED_IDLE;
        commit = (st_q == FEED_ARMED) && is_key_b;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FEED_IDLE;
    end else if (bus_sel) begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/pllreg_bank.sv
module pllreg_bank #(
  parameter int MUL_W = 15,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_cfg,
  input  logic             commit,
  input  logic             wd_en,
  input  logic             wd_conn,
  input  logic [MUL_W-1:0] wd_msel,
  input  logic [DIV_W-1:0] wd_nsel,
  output logic             hold_en,
  output logic             hold_conn,
  output logic [MUL_W-1:0] hold_msel,
  output logic [DIV_W-1:0] hold_nsel,
  output logic             sh_en,
  output logic             sh_conn,
  output logic [MUL_W-1:0] sh_msel,
  output logic [DIV_W-1:0] sh_nsel
);

  logic             hold_en_d, hold_conn_d;
  logic [MUL_W-1:0] hold_msel_d;
  logic [DIV_W-1:0] hold_nsel_d;

  always_comb begin
    hold_en_d   = hold_en;
    hold_conn_d = hold_conn;
    hold_msel_d = hold_msel;
    hold_nsel_d = hold_nsel;
    if (wr_ctrl) begin
      hold_en_d   = wd_en;
      hold_conn_d = wd_conn;
    end
    if (wr_cfg) begin
      hold_msel_d = wd_msel;
      hold_nsel_d = wd_nsel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_en   <= 1'b0;
      hold_conn <= 1'b0;
    end else if (wr_ctrl) begin
      hold_en   <= hold_en_d;
      hold_conn <= hold_conn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_msel <= '0;
      hold_nsel <= '0;
    end else if (wr_cfg) begin
      hold_msel <= hold_msel_d;
      hold_nsel <= hold_nsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en   <= 1'b0;
      sh_conn <= 1'b0;
      sh_msel <= '0;
      sh_nsel <= '0;
    end else if (commit) begin
      sh_en   <= hold_en;
      sh_conn <= hold_conn;
      sh_msel <= hold_msel;
      sh_nsel <= hold_nsel;
    end
  end

endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pllreg_pkg::*;
#(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 32,
  parameter int          MUL_W  = 15,
  parameter int          DIV_W  = 8,
  parameter logic [31:0] KEY_A  = 32'h0000_00AA,
  parameter logic [31:0] KEY_B  = 32'h0000_0055
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pll_lock,
  output logic              pll_enable,
  output logic              pll_connect,
  output logic [MUL_W-1:0]  pll_msel,
  output logic [DIV_W-1:0]  pll_nsel
);

  localparam int SYNC_STAGES = 2;

  logic             rst_i_n;
  logic             mapped, wr_ctrl, wr_cfg, wr_feed, rd_acc, commit;
  reg_idx_t         reg_idx;
  logic             hold_en, hold_conn, sh_en, sh_conn;
  logic [MUL_W-1:0] hold_msel, sh_msel;
  logic [DIV_W-1:0] hold_nsel, sh_nsel;
  logic [DATA_W-1:0] rd_d, rdata_q;

  pllreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  pllreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .mapped   (mapped),
    .reg_idx  (reg_idx),
    .wr_ctrl  (wr_ctrl),
    .wr_cfg   (wr_cfg),
    .wr_feed  (wr_feed),
    .rd_acc   (rd_acc)
  );

  pllreg_feed #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) u_feed (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .bus_sel (bus_sel),
    .wr_feed (wr_feed),
    .wdata   (bus_wdata),
    .commit  (commit)
  );

  pllreg_bank #(.MUL_W(MUL_W), .DIV_W(DIV_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_ctrl   (wr_ctrl),
    .wr_cfg    (wr_cfg),
    .commit    (commit),
    .wd_en     (bus_wdata[CTRL_EN_BIT]),
    .wd_conn   (bus_wdata[CTRL_CONN_BIT]),
    .wd_msel   (bus_wdata[MUL_W-1:0]),
    .wd_nsel   (bus_wdata[CFG_NSEL_LSB +: DIV_W]),
    .hold_en   (hold_en),
    .hold_conn (hold_conn),
    .hold_msel (hold_msel),
    .hold_nsel (hold_nsel),
    .sh_en     (sh_en),
    .sh_conn   (sh_conn),
    .sh_msel   (sh_msel),
    .sh_nsel   (sh_nsel)
  );

  always_comb begin
    rd_d = '0;
    if (mapped) begin
      unique case (reg_idx)
        REG_CTRL: begin
          rd_d[CTRL_EN_BIT]   = hold_en;
          rd_d[CTRL_CONN_BIT] = hold_conn;
        end
        REG_CFG: begin
          rd_d[MUL_W-1:0]            = hold_msel;
          rd_d[CFG_NSEL_LSB +: DIV_W] = hold_nsel;
        end
        REG_STAT: begin
          rd_d[MUL_W-1:0]            = sh_msel;
          rd_d[CFG_NSEL_LSB +: DIV_W] = sh_nsel;
          rd_d[STAT_EN_BIT]          = sh_en;
          rd_d[STAT_CONN_BIT]        = sh_conn;
          rd_d[STAT_LOCK_BIT]        = pll_lock;
        end
        default: rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rdata_q <= '0;
    end else if (rd_acc) begin
      rdata_q <= rd_d;
    end
  end

  assign bus_rdata   = rdata_q;
  assign pll_enable  = sh_en;
  assign pll_connect = sh_conn && sh_en && pll_lock;
  assign pll_msel    = sh_msel;
  assign pll_nsel    = sh_nsel;

endmodule

// File: rtl/pll_feed_regs_chk.sv
module pll_feed_regs_chk #(
  parameter int          ADDR_W = 5,
  parameter int          DATA_W = 32,
  parameter int          MUL_W  = 15,
  parameter int          DIV_W  = 8,
  parameter logic [31:0] KEY_B  = 32'h0000_0055
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              pll_lock,
  input logic              pll_enable,
  input logic              pll_connect,
  input logic [MUL_W-1:0]  pll_msel,
  input logic [DIV_W-1:0]  pll_nsel
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(12);

  logic hold_wr, stat_rd, feed_rd, key_b_wr, out_moved, stat_wr;

  always_comb begin
    hold_wr   = bus_sel && bus_wr && (bus_addr == OFS_CTRL || bus_addr == OFS_CFG);
    stat_wr   = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    stat_rd   = bus_sel && !bus_wr && (bus_addr == OFS_STAT);
    feed_rd   = bus_sel && !bus_wr && (bus_addr == OFS_FEED);
    key_b_wr  = bus_sel && bus_wr && (bus_addr == OFS_FEED) && (bus_wdata == DATA_W'(KEY_B));
  end

  // R2: staging writes leave the PLL outputs alone
  a_r2_hold_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> ($stable(pll_msel) && $stable(pll_nsel) && $stable(pll_enable)));

  // R3: outputs move only right after a closing feed write
  always_comb out_moved = 1'b0;
  a_r3_move_needs_feed: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_msel != $past(pll_msel) || pll_nsel != $past(pll_nsel) || pll_enable != $past(pll_enable))
      |-> $past(key_b_wr));

  // R4: status reports shadow values and lock
  a_r4_status_fields: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> (bus_rdata[MUL_W-1:0] == $past(pll_msel) && bus_rdata[16 +: DIV_W] == $past(pll_nsel)
                 && bus_rdata[24] == $past(pll_enable) && bus_rdata[26] == $past(pll_lock)));

  // R5: feed register reads as zero
  a_r5_feed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    feed_rd |=> (bus_rdata == '0));

  // R6: no clock switch without enable and lock
  a_r6_connect_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pll_connect |-> (pll_enable && pll_lock));

  // R9: status writes are ignored
  a_r9_stat_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !out_moved) |=> ($stable(pll_msel) && $stable(pll_nsel) && $stable(pll_enable)));

endmodule

bind pll_feed_regs pll_feed_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .MUL_W  (MUL_W),
  .DIV_W  (DIV_W),
  .KEY_B  (KEY_B)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .pll_lock    (pll_lock),
  .pll_enable  (pll_enable),
  .pll_connect (pll_connect),
  .pll_msel    (pll_msel),
  .pll_nsel    (pll_nsel)
);

// File: tb/pll_feed_regs_bench.sv
`timescale 1ns/1ps
module pll_feed_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pll_lock = 1'b0;
  logic        pll_enable, pll_connect;
  logic [14:0] pll_msel;
  logic [7:0]  pll_nsel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pll_feed_regs u_pll_feed_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pll_lock(pll_lock), .pll_enable(pll_enable), .pll_connect(pll_connect),
    .pll_msel(pll_msel), .pll_nsel(pll_nsel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // All tasks start and end 1 ns after a rising edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic outs(input string tag, input logic en, input logic cn,
                      input logic [14:0] m, input logic [7:0] n);
    chk({tag, " enable"},  {31'd0, pll_enable},  {31'd0, en});
    chk({tag, " connect"}, {31'd0, pll_connect}, {31'd0, cn});
    chk({tag, " msel"},    {17'd0, pll_msel},    {17'd0, m});
    chk({tag, " nsel"},    {24'd0, pll_nsel},    {24'd0, n});
  endtask

  // Monitor: a read sampled at an edge returns data before the next edge.
  always @(posedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      @(negedge clk);
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 unexpected read act=%h exp=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    outs("R1 reset", 0, 0, 15'h0, 8'h0);
    rd(5'h00, 32'h0, "R1 ctrl reset");
    rd(5'h04, 32'h0, "R1 cfg reset");
    rd(5'h08, 32'h0, "R1 status reset");
    rd(5'h0C, 32'h0, "R5 feed read");

    // stage values with junk in unused bits
    wr(5'h04, 32'hFF5A_9ABC);
    wr(5'h00, 32'hFFFF_FFFF);
    #1 outs("R2 staged only", 0, 0, 15'h0, 8'h0);
    rd(5'h04, 32'h005A_1ABC, "R2 cfg readback");
    rd(5'h00, 32'h0000_0003, "R2 ctrl readback");
    rd(5'h08, 32'h0000_0000, "R4 status before feed");

    wr(5'h0C, 32'h0000_00AA);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R3 after feed, no lock", 1, 0, 15'h1ABC, 8'h5A);
    rd(5'h08, 32'h035A_1ABC, "R4 status unlocked");
    pll_lock = 1'b1;
    #1 outs("R6 locked", 1, 1, 15'h1ABC, 8'h5A);
    rd(5'h08, 32'h075A_1ABC, "R4 status locked");

    // new staged values, then broken sequences
    wr(5'h04, 32'h0003_0007);
    wr(5'h00, 32'h0000_0001);
    wr(5'h0C, 32'h0000_00AA);
    rd(5'h00, 32'h0000_0001, "R7 read inside sequence");
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R7 read aborts", 1, 1, 15'h1ABC, 8'h5A);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h0C, 32'h0000_0056);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R7 wrong value aborts", 1, 1, 15'h1ABC, 8'h5A);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h04, 32'h0003_0007);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R7 cfg write aborts", 1, 1, 15'h1ABC, 8'h5A);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h14, 32'h0000_0000);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R7 unmapped write aborts", 1, 1, 15'h1ABC, 8'h5A);

    wr(5'h0C, 32'h0000_00AA);
    idle(3);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R8 idle gap accepted", 1, 0, 15'h0007, 8'h03);

    wr(5'h04, 32'h0010_0020);
    wr(5'h00, 32'h0000_0003);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h0C, 32'h0000_0055);
    #1 outs("R7 re-arm commits", 1, 1, 15'h0020, 8'h10);

    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h01, 32'hFFFF_FFFF);
    #1 outs("R9 ignored writes", 1, 1, 15'h0020, 8'h10);
    rd(5'h08, 32'h0710_0020, "R9 status unchanged");
    rd(5'h00, 32'h0000_0003, "R9 ctrl unchanged");
    rd(5'h04, 32'h0010_0020, "R9 cfg unchanged");
    rd(5'h1C, 32'h0000_0000, "R5 unmapped read");
    rd(5'h05, 32'h0000_0000, "R5 unaligned read");

    pll_lock = 1'b0;
    #1 outs("R6 lock lost", 1, 0, 15'h0020, 8'h10);
    rd(5'h08, 32'h0310_0020, "R4 status lock lost");

    wr(5'h00, 32'h0000_0002);
    wr(5'h0C, 32'h0000_00AA);
    wr(5'h0C, 32'h0000_0055);
    pll_lock = 1'b1;
    #1 outs("R6 connect without enable", 0, 0, 15'h0020, 8'h10);
    rd(5'h08, 32'h0610_0020, "R4 status enable off");

    idle(3);
    chk("R5 all reads answered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule